// File: doc/BRIEF.md
# Receiver Signal-Loss Detector

This block watches a group of serial receiver lines and reports whether any of them carries a proper signalling level. Each line arrives as two digital flags from analog comparators, which are not part of this block. The first flag says the line magnitude is at or above the valid threshold. The second says the magnitude lies in the narrow band around zero. A line pulled to ground with nothing attached shows up as that near-zero case. A line with neither flag set sits between the two thresholds.

The output is an active-low loss indicator, `loss_n_o`. It goes high quickly, after a short qualification on any one valid line. It goes low slowly, only after every line has stayed near zero for a long window. Both windows are counted in clock cycles and set by parameters. The indicator runs the same way in every power mode. Nothing inside the block changes the power state. Any link between this flag and power control is made by the system around it.

Top module: `rx_loss_detect`

## Requirements
- R1: During reset, and from the end of reset until a rise qualification completes, `loss_n_o` is 0.
- R2: Each channel is classified on its own each cycle. Channel bit i of `ch_valid_i` = 1 means valid, whatever bit i of `ch_quiet_i` holds. `ch_valid_i[i]`=0 with `ch_quiet_i[i]`=1 means invalid. Both bits 0 means indeterminate.
- R3: `loss_n_o` becomes 1 on the clock edge that samples the RISE_CYC-th consecutive cycle in which at least one channel is valid. The valid channel may change from cycle to cycle.
- R4: A sampled cycle with no valid channel restarts the rise qualification from zero.
- R5: `loss_n_o` becomes 0 on the clock edge that samples the FALL_CYC-th cycle of the fall qualification. Only cycles in which all channels are invalid count toward it.
- R6: A sampled cycle with any valid channel restarts the fall qualification from zero.
- R7: A cycle with no valid channel and at least one indeterminate channel neither advances nor restarts the fall qualification, and it leaves `loss_n_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_valid_i | input | NUM_CH | Per-channel flag: magnitude at or above the valid threshold |
| ch_quiet_i | input | NUM_CH | Per-channel flag: magnitude inside the near-zero band |
| loss_n_o | output | 1 | 1 = a valid level is qualified; 0 = signal lost |

## Verification
`loss_n_o` is a register. A new input vector therefore shows its effect on the output one clock after the edge that samples it. A qualification of N cycles completes on the N-th sampling edge. The driver applies each vector on a falling edge and queues the flag value that the requirements predict after the next rising edge. The monitor reads the output one nanosecond after that rising edge. At that point the queue holds exactly the item for the vector just sampled, so every comparison lines up with the edge that caused it.

// File: rtl/rx_loss_pkg.sv
// Shared types for the receiver signal-loss detector.
// Assumes: nothing beyond IEEE 1800-2017.
package rx_loss_pkg;

    // Level class of one receiver channel
    typedef enum logic [1:0] {
        CH_QUIET = 2'd0,   // magnitude inside the near-zero band
        CH_MID   = 2'd1,   // indeterminate band
        CH_VALID = 2'd2    // valid signalling level
    } ch_cls_e;

    // Width needed for a counter that saturates at lim-1
    function automatic int unsigned cnt_width(input int unsigned lim);
        int unsigned w;
        w = (lim > 1) ? $clog2(lim) : 1;
        return w;
    endfunction

endpackage

// File: rtl/ch_classify.sv
// Turns the two comparator flags of every channel into a level class.
// Assumes: the valid flag wins when both flags are set, because the
// valid threshold is the stronger evidence of a driven line.
module ch_classify
    import rx_loss_pkg::*;
#(
    parameter int unsigned NUM_CH = 5
) (
    input  logic [NUM_CH-1:0] valid_i,
    input  logic [NUM_CH-1:0] quiet_i,
    output ch_cls_e           cls_o [NUM_CH]
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // Per-channel priority decode: valid, then quiet, else indeterminate
        always_comb begin
            if (valid_i[g])
                cls_o[g] = CH_VALID;
            else if (quiet_i[g])
                cls_o[g] = CH_QUIET;
            else
                cls_o[g] = CH_MID;
        end
    end

endmodule

// File: rtl/qual_counter.sv
// Saturating qualification counter. It counts sampled cycles with
// adv_i set, clears on clr_i, and otherwise holds. hit_o flags the
// cycle whose sampling edge completes LIMIT advancing cycles, and
// every further advancing cycle after that.
// Assumes: LIMIT >= 1; adv_i and clr_i are never set together.
module qual_counter #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    input  logic clr_i,
    output logic hit_o
);

    localparam int unsigned CW = rx_loss_pkg::cnt_width(LIMIT);
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Count advancing cycles up to TOP, clear on request, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (adv_i && (cnt_q != TOP))
            cnt_q <= cnt_q + 1'b1;
    end

    // Completion flag for the current sampled cycle
    assign hit_o = adv_i && (cnt_q == TOP);

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !clr_i) |=> $stable(cnt_q));

    // R4
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !hit_o || (TOP == '0));

endmodule

// File: rtl/rx_loss_detect.sv
// Receiver signal-loss detector. It classifies every channel, runs a
// short rise qualification on "any channel valid" and a long fall
// qualification on "all channels invalid", and drives an active-low
// loss flag from a single register.
// Assumes: comparator flags are already synchronous to clk. The flag
// has no effect on power mode.
module rx_loss_detect
    import rx_loss_pkg::*;
#(
    parameter int unsigned NUM_CH   = 5,
    parameter int unsigned RISE_CYC = 100,
    parameter int unsigned FALL_CYC = 3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_valid_i,
    input  logic [NUM_CH-1:0] ch_quiet_i,
    output logic              loss_n_o
);

    ch_cls_e cls [NUM_CH];
    logic    any_valid;
    logic    all_quiet;
    logic    rise_hit;
    logic    fall_hit;
    logic    flag_q;

    ch_classify #(.NUM_CH(NUM_CH)) u_cls (
        .valid_i (ch_valid_i),
        .quiet_i (ch_quiet_i),
        .cls_o   (cls)
    );

    // Reduce channel classes to the two group conditions
    always_comb begin
        any_valid = 1'b0;
        all_quiet = 1'b1;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cls[i] == CH_VALID) any_valid = 1'b1;
            if (cls[i] != CH_QUIET) all_quiet = 1'b0;
        end
    end

    qual_counter #(.LIMIT(RISE_CYC)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (any_valid),
        .clr_i (!any_valid),
        .hit_o (rise_hit)
    );

    qual_counter #(.LIMIT(FALL_CYC)) u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (all_quiet),
        .clr_i (any_valid),
        .hit_o (fall_hit)
    );

    // Loss flag register: set on rise completion, clear on fall completion
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (rise_hit)
            flag_q <= 1'b1;
        else if (fall_hit)
            flag_q <= 1'b0;
    end

    assign loss_n_o = flag_q;

    // R3
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(any_valid));

    // R5
    fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(all_quiet));

    // R7
    mid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_valid && !all_quiet) |=> $stable(flag_q));

    // R2
    excl_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(any_valid && all_quiet));

endmodule

// File: tb/rx_loss_detect_bench.sv
// Scoreboard bench: a driver task applies a vector on a falling edge and
// queues the expected flag. A monitor pops and compares it just after the
// next rising edge.
module rx_loss_detect_bench;

    localparam int    CLK_PERIOD = 10;
    localparam int    N   = 5;
    localparam int    RC  = 4;
    localparam int    FC  = 40;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] vld = '0;
    logic [N-1:0] qui = '0;
    logic         loss_n;

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    logic  exp_q[$];
    string tag_q[$];
    int    m_rise = 0;
    int    m_fall = 0;
    logic  m_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_loss_detect #(.NUM_CH(N), .RISE_CYC(RC), .FALL_CYC(FC)) u_rx_loss_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .ch_valid_i (vld),
        .ch_quiet_i (qui),
        .loss_n_o   (loss_n)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: loss_n_o=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one vector and queue the requirement-derived result
    task automatic step(input logic [N-1:0] v, input logic [N-1:0] q, input string tag);
        logic anyv, allq;
        @(negedge clk);
        vld = v;
        qui = q;
        anyv = |v;
        allq = &(q & ~v);
        if (anyv) begin
            m_fall = 0;
            m_rise = (m_rise < RC) ? m_rise + 1 : RC;
            if (m_rise >= RC) m_flag = 1'b1;
        end else begin
            m_rise = 0;
            if (allq) begin
                m_fall = (m_fall < FC) ? m_fall + 1 : FC;
                if (m_fall >= FC) m_flag = 1'b0;
            end
        end
        exp_q.push_back(m_flag);
        tag_q.push_back(tag);
    endtask

    task automatic repeat_step(input int n, input logic [N-1:0] v, input logic [N-1:0] q,
                               input string tag);
        for (int i = 0; i < n; i++) step(v, q, tag);
    endtask

    // Monitor: compare one queued item after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) check(loss_n, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(loss_n, 1'b0, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R1: all quiet keeps the flag low
        repeat_step(10, '0, '1, "R1 low after reset");
        // R4: short valid burst on channel 2 then a quiet gap
        repeat_step(RC - 1, 5'b00100, 5'b11011, "R4 burst too short");
        step('0, '1, "R4 gap restarts rise");
        // R3: valid rotating over channels, flag rises on RC-th cycle
        for (int c = 0; c < RC + 2; c++)
            step(N'(1) << (c % N), ~(N'(1) << (c % N)), "R3 any channel rise");
        // R7: indeterminate only, flag holds high for long time
        repeat_step(FC + 10, '0, 5'b10111, "R7 mid holds high");
        // R5/R7: quiet 30, mid 20 (hold), quiet 10 -> falls
        repeat_step(30, '0, '1, "R5 fall partial");
        repeat_step(20, '0, 5'b11110, "R7 mid holds count");
        repeat_step(12, '0, '1, "R5 fall completes");
        // R2: both flags on one channel counts as valid
        repeat_step(RC + 1, 5'b01000, '1, "R2 valid wins over quiet");
        // R6: a valid cycle restarts fall qualification
        repeat_step(FC - 1, '0, '1, "R6 before break");
        step(5'b10000, 5'b01111, "R6 break");
        repeat_step(FC - 1, '0, '1, "R6 after break");
        repeat_step(2, '0, '1, "R5 fall after full window");
        // R2: indeterminate everywhere does not qualify rise
        repeat_step(RC + 3, '0, '0, "R2 mid not valid");
        repeat (2) @(posedge clk);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule